// File: doc/BRIEF.md
# Microprogram Sequencer with Shared Return/Loop Stack

This block drives the control store of a microcoded control unit. It keeps a micro-address counter and reads the addressed microword from a small on-block ROM. It then latches that word into a pipeline register, whose bits drive the datapath for one cycle. The sequencing fields of the word in the pipeline register choose the next micro-address. The choices are: step by one, jump, dispatch on an opcode-derived address, enter an interrupt vector, branch on a registered ALU flag, call or return from a microsubroutine, or close a counted loop.

Loop start addresses and subroutine return addresses share one six-entry LIFO. A single loop counter counts down the remaining passes of the innermost loop. An external vector request overrides every other choice for one cycle. The address register and the pipeline register are both clocked, so a taken branch always lets the sequential word already fetched execute in the following cycle. Microcode is written with this delay slot in mind.

Top module: `useq_top`

## Requirements
- R1: During and right after a synchronous active-low reset, `uaddr` is 0, `ctrl_word` is all zeros (step, no stack action), both stack flags are 0, the stack is empty, the loop counter is 0 and the registered flags are 0.
- R2: When `vec_req` is 0 and the executing word's sequence op (bits 27:25) is 0 (STEP), the next `uaddr` is `uaddr`+1 modulo 64.
- R3: With `vec_req` at 0, op 1 (JUMP) loads the branch field (bits 19:14), op 2 (DISPATCH) loads `map_addr` and op 3 (VECTOR) loads `vec_addr`.
- R4: `vec_req` at 1 makes the next `uaddr` equal `vec_addr`, whatever the executing word holds. The stack, the loop counter and both stack flags are left untouched.
- R5: Op 4 (BRANCH-IF) jumps to the branch field when the bit of `alu_flags` selected by bits 22:21, as registered at the previous clock edge, XOR the polarity bit 20 is 1. Otherwise it steps.
- R6: `ctrl_word` always holds the ROM word of the address that `uaddr` showed one cycle earlier. Its bits 5:0 echo that address. After any taken branch, the word at the sequential address still executes (one delay slot).
- R7: Op 5 (CALL) pushes `uaddr`+1 and jumps to the branch field. Op 6 (RETURN) pops and goes to the popped address, in LIFO order, up to 6 levels.
- R8: Op 0 with auxiliary field (bits 24:23) = 1 (LOOP-OPEN) pushes the current `uaddr`, loads the loop counter from branch bits 17:14 and steps. Op 7 (LOOP-CLOSE) with a nonzero counter decrements it and goes to the top-of-stack address without popping. With a zero counter it pops and steps.
- R9: Op 0 with auxiliary field = 2 (ABANDON) pops one entry without using it and steps.
- R10: A push onto a full stack leaves the stack unchanged and sets `stk_ovf` for exactly the following cycle.
- R11: A pop from an empty stack sets `stk_unf` for exactly the following cycle. A RETURN in that case goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| map_addr | input | 6 | Dispatch address from the opcode bits of the instruction register |
| vec_req | input | 1 | Interrupt request forcing a vector entry |
| vec_addr | input | 6 | Interrupt vector micro-address |
| alu_flags | input | 4 | ALU status flags, registered inside the block |
| uaddr | output | 6 | Current control-store address |
| ctrl_word | output | 28 | Pipelined microword: op 27:25, aux 24:23, flag select 22:21, polarity 20, branch 19:14, datapath controls 13:6, address echo 5:0 |
| stk_ovf | output | 1 | One-cycle pulse after a push onto a full stack |
| stk_unf | output | 1 | One-cycle pulse after a pop from an empty stack |

## Verification
A corrupted stack entry or pointer stays hidden until a RETURN or LOOP-CLOSE consumes it. From then on `uaddr` diverges within one cycle, and the echoed address in `ctrl_word` diverges one cycle after that. A wrong loop count shows only when the loop closes one pass early or late. A status register that is skipped or doubled shows on the first BRANCH-IF whose selected flag changed between cycles. The bench therefore keeps its own stack, counter and flag history across thousands of random cycles and compares every cycle's address, echo and flags.

// File: rtl/useq_pkg.sv
// Shared widths, microword layout and control-store contents for the
// microprogram sequencer. Assumes a 64-word control store.
package useq_pkg;

    localparam int UA_W  = 6;                 // micro-address width
    localparam int CTL_W = 8;                 // datapath control bits
    localparam int FLG_W = 4;                 // ALU flag count
    localparam int SEL_W = $clog2(FLG_W);     // flag select width
    localparam int CNT_W = 4;                 // loop counter width
    localparam int ROM_N = 1 << UA_W;         // control-store words

    typedef enum logic [2:0] {
        SQ_STEP = 3'd0, SQ_JUMP = 3'd1, SQ_MAP  = 3'd2, SQ_VEC  = 3'd3,
        SQ_COND = 3'd4, SQ_CALL = 3'd5, SQ_RET  = 3'd6, SQ_LOOP = 3'd7
    } seq_op_e;

    typedef enum logic [1:0] {
        AX_NONE = 2'd0, AX_LOOPOPEN = 2'd1, AX_DROP = 2'd2, AX_SPARE = 2'd3
    } aux_e;

    typedef struct packed {
        seq_op_e             op;
        aux_e                aux;
        logic [SEL_W-1:0]    csel;
        logic                cpol;
        logic [UA_W-1:0]     br;
        logic [CTL_W-1:0]    ctl;
        logic [UA_W-1:0]     tag;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    // Computes the microword stored at address a. The top eight words
    // form a call chain followed by returns, giving deep nesting.
    function automatic uword_t rom_word(input int unsigned a);
        uword_t      w;
        logic [31:0] v;
        v      = (a ^ (a >> 3));
        w.op   = seq_op_e'(v[2:0]);
        v      = a >> 1;
        w.aux  = aux_e'(v[1:0]);
        v      = a >> 3;
        w.csel = v[SEL_W-1:0];
        v      = a >> 5;
        w.cpol = v[0];
        v      = a * 13 + 7;
        w.br   = v[UA_W-1:0];
        v      = a * 29 + 5;
        w.ctl  = v[CTL_W-1:0];
        v      = a;
        w.tag  = v[UA_W-1:0];
        if (a >= ROM_N - 8) begin
            if (a < ROM_N - 4) begin
                w.op = SQ_CALL;
                v    = a + 1;
                w.br = v[UA_W-1:0];
            end else begin
                w.op = SQ_RET;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_rom.sv
// Control store: asynchronous-read ROM whose contents come from
// rom_word(). Assumes the address covers the whole array.
module useq_rom
    import useq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);

    uword_t mem [ROM_N];

    // Fill every word from the content function.
    for (genvar g = 0; g < ROM_N; g++) begin : g_word
        assign mem[g] = rom_word(g);
    end

    // Read the addressed word.
    assign word = mem[addr];

endmodule

// File: rtl/useq_stack.sv
// LIFO of micro-addresses shared by loops and subroutines. A push when
// full and a pop when empty are ignored; top reads 0 when empty.
// Assumes push and pop are never requested in the same cycle.
module useq_stack #(
    parameter int W     = 6,
    parameter int DEPTH = 6,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [PW-1:0] depth,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  ent [DEPTH];
    logic [PW-1:0] cnt_q;

    assign full  = (cnt_q == PW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign depth = cnt_q;

    // One register per level, written when it is the next free slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (push && !full && cnt_q == PW'(g))
                ent[g] <= din;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push && !full)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && !empty)
            cnt_q <= cnt_q - 1'b1;
    end

    // Select the most recent entry.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == PW'(i + 1))
                top = ent[i];
    end

endmodule

// File: rtl/useq_next.sv
// Next-address selection and stack/counter commands for one cycle.
// Purely combinational; assumes the caller registers its results.
module useq_next
    import useq_pkg::*;
(
    input  seq_op_e          op,
    input  aux_e             aux,
    input  logic [SEL_W-1:0] csel,
    input  logic             cpol,
    input  logic [UA_W-1:0]  br,
    input  logic [UA_W-1:0]  ua,
    input  logic [UA_W-1:0]  map_addr,
    input  logic             vec_req,
    input  logic [UA_W-1:0]  vec_addr,
    input  logic [FLG_W-1:0] status,
    input  logic [UA_W-1:0]  stk_top,
    input  logic             stk_full,
    input  logic             stk_empty,
    input  logic             cnt_zero,
    output logic [UA_W-1:0]  nxt_ua,
    output logic             push,
    output logic [UA_W-1:0]  push_val,
    output logic             pop,
    output logic             cnt_load,
    output logic             cnt_dec,
    output logic             ovf_evt,
    output logic             unf_evt
);

    logic [UA_W-1:0] ua_inc;
    assign ua_inc = ua + 1'b1;

    // Decode the executing word into an address and side effects.
    always_comb begin
        nxt_ua   = ua_inc;
        push     = 1'b0;
        push_val = ua_inc;
        pop      = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        if (vec_req) begin
            nxt_ua = vec_addr;
        end else begin
            unique case (op)
                SQ_STEP: begin
                    if (aux == AX_LOOPOPEN) begin
                        push     = 1'b1;
                        push_val = ua;
                        cnt_load = 1'b1;
                    end else if (aux == AX_DROP) begin
                        pop = 1'b1;
                    end
                end
                SQ_JUMP: nxt_ua = br;
                SQ_MAP:  nxt_ua = map_addr;
                SQ_VEC:  nxt_ua = vec_addr;
                SQ_COND: if (status[csel] ^ cpol) nxt_ua = br;
                SQ_CALL: begin
                    push   = 1'b1;
                    nxt_ua = br;
                end
                SQ_RET: begin
                    pop    = 1'b1;
                    nxt_ua = stk_top;
                end
                SQ_LOOP: begin
                    if (!cnt_zero) begin
                        cnt_dec = 1'b1;
                        nxt_ua  = stk_top;
                    end else begin
                        pop = 1'b1;
                    end
                end
                default: nxt_ua = ua_inc;
            endcase
        end
    end

    assign ovf_evt = push && stk_full;
    assign unf_evt = pop && stk_empty;

endmodule

// File: rtl/useq_top.sv
// Microprogram sequencer: address register, control store, microword
// pipeline register, registered ALU flags, loop counter and shared
// stack. The word in the pipeline register sequences the next address,
// so every taken branch has one delay slot.
module useq_top
    import useq_pkg::*;
#(
    parameter int  STK_DEPTH = 6,
    localparam int DPW       = $clog2(STK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UA_W-1:0]  map_addr,
    input  logic             vec_req,
    input  logic [UA_W-1:0]  vec_addr,
    input  logic [FLG_W-1:0] alu_flags,
    output logic [UA_W-1:0]  uaddr,
    output logic [UW_W-1:0]  ctrl_word,
    output logic             stk_ovf,
    output logic             stk_unf
);

    logic [UA_W-1:0]  ua_q;
    uword_t           pipe_q;
    uword_t           rom_q;
    logic [FLG_W-1:0] status_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, unf_q;

    logic [UA_W-1:0]  nxt_ua, push_val, stk_top;
    logic             push, pop, cnt_load, cnt_dec, ovf_evt, unf_evt;
    logic             stk_full, stk_empty;
    logic [DPW-1:0]   stk_depth;

    useq_rom i_rom (
        .addr (ua_q),
        .word (rom_q)
    );

    useq_stack #(.W(UA_W), .DEPTH(STK_DEPTH)) i_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (push_val),
        .top   (stk_top),
        .depth (stk_depth),
        .full  (stk_full),
        .empty (stk_empty)
    );

    useq_next i_next (
        .op        (pipe_q.op),
        .aux       (pipe_q.aux),
        .csel      (pipe_q.csel),
        .cpol      (pipe_q.cpol),
        .br        (pipe_q.br),
        .ua        (ua_q),
        .map_addr  (map_addr),
        .vec_req   (vec_req),
        .vec_addr  (vec_addr),
        .status    (status_q),
        .stk_top   (stk_top),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .cnt_zero  (cnt_q == '0),
        .nxt_ua    (nxt_ua),
        .push      (push),
        .push_val  (push_val),
        .pop       (pop),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec),
        .ovf_evt   (ovf_evt),
        .unf_evt   (unf_evt)
    );

    // Address register, microword pipeline and flag status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ua_q     <= '0;
            pipe_q   <= '0;
            status_q <= '0;
        end else begin
            ua_q     <= nxt_ua;
            pipe_q   <= rom_q;
            status_q <= alu_flags;
        end
    end

    // Loop counter: loaded on loop open, decremented on a repeat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_load)
            cnt_q <= pipe_q.br[CNT_W-1:0];
        else if (cnt_dec)
            cnt_q <= cnt_q - 1'b1;
    end

    // One-cycle stack error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_evt;
            unf_q <= unf_evt;
        end
    end

    assign uaddr     = ua_q;
    assign ctrl_word = pipe_q;
    assign stk_ovf   = ovf_q;
    assign stk_unf   = unf_q;

endmodule

// File: rtl/useq_chk.sv
// Property checker for useq_top, attached by bind. Observes ports and
// the stack occupancy; drives nothing.
module useq_chk
    import useq_pkg::*;
#(
    parameter int  STK_DEPTH = 6,
    localparam int DPW       = $clog2(STK_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_req,
    input logic [UA_W-1:0] vec_addr,
    input logic [UA_W-1:0] uaddr,
    input logic [UW_W-1:0] ctrl_word,
    input logic            stk_ovf,
    input logic            stk_unf,
    input logic [DPW-1:0]  depth
);

    uword_t w;
    assign w = uword_t'(ctrl_word);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (w.op == SQ_STEP && !vec_req) |=> uaddr == $past(uaddr) + 1'b1);

    assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w.op == SQ_JUMP && !vec_req) |=> uaddr == $past(w.br));

    assert_vector_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> (uaddr == $past(vec_addr) && !stk_ovf && !stk_unf));

    assert_pipe_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> w.tag == $past(uaddr));

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DPW'(STK_DEPTH));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |-> (depth == DPW'(STK_DEPTH) && $stable(depth)));

    assert_empty_on_unf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |-> (depth == '0 && $stable(depth)));

endmodule

bind useq_top useq_chk #(.STK_DEPTH(STK_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_req   (vec_req),
    .vec_addr  (vec_addr),
    .uaddr     (uaddr),
    .ctrl_word (ctrl_word),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf),
    .depth     (stk_depth)
);

// File: tb/test_useq_top.sv
// Self-checking bench: random dispatch, vector and flag stimulus with a
// bench-side model of the stack, loop counter and flag register.
module test_useq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] map_addr = '0;
    logic       vec_req = 1'b0;
    logic [5:0] vec_addr = '0;
    logic [3:0] alu_flags = '0;
    logic [5:0] uaddr;
    logic [27:0] ctrl_word;
    logic       stk_ovf, stk_unf;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    useq_top i_useq_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_addr  (map_addr),
        .vec_req   (vec_req),
        .vec_addr  (vec_addr),
        .alu_flags (alu_flags),
        .uaddr     (uaddr),
        .ctrl_word (ctrl_word),
        .stk_ovf   (stk_ovf),
        .stk_unf   (stk_unf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model state.
    int stk [6];
    int sp = 0;
    int cnt = 0;
    int flags_prev = 0;
    int n_ovf = 0, n_unf = 0, n_rep = 0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int eua, eov, eun, mu, op, aux, csel, cpol, br, vreq, vadr, madr, flg;
        string lbl;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state visible while reset is held
        check(uaddr == 0, "R1 uaddr in reset", int'(uaddr), 0);
        check(ctrl_word == 0, "R1 ctrl_word in reset", int'(ctrl_word), 0);
        check(!stk_ovf && !stk_unf, "R1 stack flags in reset", int'({stk_ovf, stk_unf}), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            mu   = int'(uaddr);
            op   = int'(ctrl_word[27:25]);
            aux  = int'(ctrl_word[24:23]);
            csel = int'(ctrl_word[22:21]);
            cpol = int'(ctrl_word[20]);
            br   = int'(ctrl_word[19:14]);
            // Stimulus: mostly random, with directed vectors into the
            // call chain (56) and the return tail (60) early on.
            vreq = ($urandom % 7 == 0) ? 1 : 0;
            vadr = int'($urandom % 64);
            if (cyc == 2)  begin vreq = 1; vadr = 56; end
            if (cyc == 40) begin vreq = 1; vadr = 60; end
            madr = int'($urandom % 64);
            flg  = int'($urandom % 16);
            vec_req   = vreq[0];
            vec_addr  = vadr[5:0];
            map_addr  = madr[5:0];
            alu_flags = flg[3:0];
            // Expected next state.
            eua = (mu + 1) % 64; eov = 0; eun = 0; lbl = "R2 step";
            if (vreq == 1) begin
                eua = vadr; lbl = "R4 vector override";
            end else begin
                case (op)
                    0: begin
                        if (aux == 1) begin
                            lbl = "R8 loop open";
                            if (sp == 6) eov = 1; else begin stk[sp] = mu; sp++; end
                            cnt = br % 16;
                        end else if (aux == 2) begin
                            lbl = "R9 abandon";
                            if (sp == 0) eun = 1; else sp--;
                        end
                    end
                    1: begin eua = br; lbl = "R3 jump"; end
                    2: begin eua = madr; lbl = "R3 dispatch"; end
                    3: begin eua = vadr; lbl = "R3 vector op"; end
                    4: begin
                        lbl = "R5 conditional";
                        if ((((flags_prev >> csel) & 1) ^ cpol) == 1) eua = br;
                    end
                    5: begin
                        lbl = "R7 call";
                        if (sp == 6) eov = 1; else begin stk[sp] = (mu + 1) % 64; sp++; end
                        eua = br;
                    end
                    6: begin
                        lbl = "R7 return";
                        if (sp == 0) begin eun = 1; eua = 0; end
                        else begin sp--; eua = stk[sp]; end
                    end
                    default: begin
                        lbl = "R8 loop close";
                        if (cnt != 0) begin
                            cnt--; n_rep++;
                            eua = (sp == 0) ? 0 : stk[sp - 1];
                        end else if (sp == 0) eun = 1;
                        else sp--;
                    end
                endcase
            end
            flags_prev = flg;
            @(negedge clk);
            check(int'(uaddr) == eua, lbl, int'(uaddr), eua);
            if (eov == 1) begin n_ovf++; lbl = "R10 overflow pulse"; end
            else lbl = "R10 no overflow";
            check(int'(stk_ovf) == eov, lbl, int'(stk_ovf), eov);
            if (eun == 1) begin n_unf++; lbl = "R11 underflow pulse"; end
            else lbl = "R11 no underflow";
            check(int'(stk_unf) == eun, lbl, int'(stk_unf), eun);
            // R6: pipeline echo; after a taken branch this is the delay slot
            if (eua != (mu + 1) % 64)
                check(int'(ctrl_word[5:0]) == mu, "R6 delay slot word", int'(ctrl_word[5:0]), mu);
            else
                check(int'(ctrl_word[5:0]) == mu, "R6 pipeline echo", int'(ctrl_word[5:0]), mu);
        end
        $display("coverage: overflows=%0d underflows=%0d loop repeats=%0d", n_ovf, n_unf, n_rep);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule